// File: doc/BRIEF.md
# SDRAM Low-Power Mode Manager

This block sits between an SDRAM command sequencer and the memory pins. It decides when the device goes into a low-power state and when it comes back out. While the device is awake, it passes the sequencer's command straight to the pins and holds clock-enable high. It counts the idle cycles during which no access is requested. Once the configured idle timeout has run out and a low-power mode is enabled, it takes over the pins. It then issues a precharge-all, waits out the row precharge time, and issues the entry command for the selected mode with clock-enable low.

Three sleep kinds are supported, and each owns refresh differently:
- **Self-refresh:** the device refreshes itself.
- **Power-down:** refresh stays with the controller. Every refresh tick wakes the device briefly to issue an auto-refresh and then puts it back down.
- **Deep power-down:** memory contents are lost. This kind is allowed only when the part is configured as mobile SDRAM, and leaving it needs a full re-initialisation by outside logic.

From the first entry command until the device is usable again, a wait output stalls the requesting master instead of dropping its access.

Top module: `sdram_lp_mgr`

## Requirements
- R1: After reset, cke_o is 1, wait_o is 0, init_req_o is 0 and cmd_o equals seq_cmd.
- R2: Whenever wait_o is 0, cmd_o equals seq_cmd and cke_o is 1. Commands are coded {ras_n,cas_n,we_n}: 111 no-op, 010 precharge-all, 001 auto-refresh, 110 deep power-down entry.
- R3: cfg_mode selects the sleep kind: 0 none, 1 self-refresh, 2 power-down, 3 deep power-down. Code 3 with cfg_mobile at 0 behaves as 0. With no sleep kind selected, the block never leaves the awake state.
- R4: cfg_timeout sets the idle limit L: 0 gives L=0, 1 gives L=IDLE_SHORT, and 2 or 3 give L=IDLE_LONG. Precharge-all appears in the cycle after the clock edge that samples req low for the (L+1)-th consecutive time. Any edge that samples req high restarts the count.
- R5: Entry issues one precharge-all cycle, then T_RP-1 no-op cycles with cke_o at 1, then one entry cycle with cke_o at 0. The entry command is 001 for self-refresh, 111 for power-down and 110 for deep power-down. After that, cke_o stays 0 with no-op.
- R6: wait_o is 1 from the precharge-all cycle until the exit sequence ends. A req raised during entry does not cut the entry short.
- R7: In self-refresh, an edge that samples req high raises cke_o. The block then gives T_XS no-op cycles with wait_o at 1, after which wait_o falls.
- R8: In power-down, an edge that samples req high gives T_XP no-op cycles with cke_o at 1 and wait_o at 1, after which wait_o falls.
- R9: In power-down, an edge that samples refresh_tick high starts a refresh sequence. It gives one no-op cycle with cke_o at 1, then one auto-refresh cycle, then T_RC-1 no-op cycles, and then cke_o returns to 0. wait_o stays 1 throughout.
- R10: refresh_tick has no effect while awake or in self-refresh.
- R11: In deep power-down, an edge that samples req high sets cke_o to 1 and init_req_o to 1, and passes seq_cmd to cmd_o. wait_o stays 1 until an edge samples init_done high. In the next cycle, wait_o and init_req_o are both 0.
- R12: The sleep kind is captured at entry. Changing cfg_mode while asleep does not change the exit sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Sleep kind select |
| cfg_timeout | input | 2 | Idle limit select |
| cfg_mobile | input | 1 | Permits deep power-down |
| req | input | 1 | Device select / access request |
| refresh_tick | input | 1 | Refresh due pulse from the refresh timer |
| init_done | input | 1 | Re-initialisation finished pulse |
| seq_cmd | input | 3 | Sequencer command {ras_n,cas_n,we_n} |
| cke_o | output | 1 | SDRAM clock-enable |
| cmd_o | output | 3 | Command to the pins {ras_n,cas_n,we_n} |
| wait_o | output | 1 | Stall to the requesting master |
| init_req_o | output | 1 | Re-initialisation required |

## Verification
The bench builds the block with IDLE_SHORT=8 and IDLE_LONG=16, so both timeout codes can be measured exactly within a few dozen cycles. It also builds the block with T_RP=3, T_RC=8, T_XS=8 and T_XP=1. With these values, the precharge gap, the refresh gap and the two distinct exit latencies (9 and 2 cycles to wait release) can each be told apart. That difference in exit latency is what exposes a sleep kind that was not captured at entry.

// File: rtl/sdram_lp_mgr.sv
module sdram_lp_mgr #(
  parameter int IDLE_SHORT = 64,
  parameter int IDLE_LONG  = 128,
  parameter int T_RP       = 3,
  parameter int T_RC       = 8,
  parameter int T_XS       = 8,
  parameter int T_XP       = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_mode,
  input  logic [1:0] cfg_timeout,
  input  logic       cfg_mobile,
  input  logic       req,
  input  logic       refresh_tick,
  input  logic       init_done,
  input  logic [2:0] seq_cmd,
  output logic       cke_o,
  output logic [2:0] cmd_o,
  output logic       wait_o,
  output logic       init_req_o
);
  localparam int IW   = $clog2(IDLE_LONG + 1);
  localparam int TA   = (T_RP > T_RC) ? T_RP : T_RC;
  localparam int TB   = (T_XS > T_XP) ? T_XS : T_XP;
  localparam int TMAX = (TA > TB) ? TA : TB;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [2:0] C_NOP = 3'b111;
  localparam logic [2:0] C_PRE = 3'b010;
  localparam logic [2:0] C_REF = 3'b001;
  localparam logic [2:0] C_DPD = 3'b110;

  typedef enum logic [3:0] {
    S_ACT, S_PRE, S_TRP, S_ENT, S_SLP, S_XIT, S_RUP, S_RFS, S_RWT, S_INI
  } st_t;

  st_t            st;
  logic [1:0]     kind;
  logic [IW-1:0]  idle;
  logic [IW-1:0]  limit;
  logic [TW-1:0]  tmr;
  logic           lp_ok;
  logic           go_sleep;

  assign lp_ok = (cfg_mode == 2'd1) || (cfg_mode == 2'd2) ||
                 ((cfg_mode == 2'd3) && cfg_mobile);

  always_comb begin
    case (cfg_timeout)
      2'd0:    limit = '0;
      2'd1:    limit = IW'(IDLE_SHORT);
      default: limit = IW'(IDLE_LONG);
    endcase
  end

  assign go_sleep = lp_ok && !req && (idle >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_ACT;
      kind <= 2'd0;
      idle <= '0;
      tmr  <= '0;
    end else begin
      case (st)
        S_ACT: begin
          if (req) idle <= '0;
          else if (idle != IW'(IDLE_LONG)) idle <= idle + IW'(1);
          if (go_sleep) begin
            st   <= S_PRE;
            kind <= cfg_mode;
            idle <= '0;
          end
        end
        S_PRE: begin
          st  <= S_TRP;
          tmr <= TW'(T_RP - 2);
        end
        S_TRP: begin
          if (tmr == '0) st <= S_ENT;
          else tmr <= tmr - TW'(1);
        end
        S_ENT: st <= S_SLP;
        S_SLP: begin
          if (kind == 2'd3) begin
            if (req) st <= S_INI;
          end else if (kind == 2'd2 && refresh_tick) begin
            st <= S_RUP;
          end else if (req) begin
            st  <= S_XIT;
            tmr <= (kind == 2'd1) ? TW'(T_XS - 1) : TW'(T_XP - 1);
          end
        end
        S_XIT: begin
          if (tmr == '0) st <= S_ACT;
          else tmr <= tmr - TW'(1);
        end
        S_RUP: st <= S_RFS;
        S_RFS: begin
          st  <= S_RWT;
          tmr <= TW'(T_RC - 2);
        end
        S_RWT: begin
          if (tmr == '0) st <= S_SLP;
          else tmr <= tmr - TW'(1);
        end
        S_INI: if (init_done) st <= S_ACT;
        default: st <= S_ACT;
      endcase
    end
  end

  assign cke_o      = !((st == S_ENT) || (st == S_SLP));
  assign wait_o     = (st != S_ACT);
  assign init_req_o = (st == S_INI);

  always_comb begin
    case (st)
      S_ACT, S_INI: cmd_o = seq_cmd;
      S_PRE:        cmd_o = C_PRE;
      S_RFS:        cmd_o = C_REF;
      S_ENT:        cmd_o = (kind == 2'd1) ? C_REF : (kind == 2'd3) ? C_DPD : C_NOP;
      default:      cmd_o = C_NOP;
    endcase
  end
endmodule

// File: rtl/sdram_lp_mgr_chk.sv
module sdram_lp_mgr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_mode,
  input logic       cfg_mobile,
  input logic [2:0] seq_cmd,
  input logic       cke_o,
  input logic [2:0] cmd_o,
  input logic       wait_o,
  input logic       init_req_o
);
  p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_o |-> (cke_o && cmd_o == seq_cmd));

  p_cke_low_waits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_o |-> wait_o);

  p_init_waits_r11: assert property (@(posedge clk) disable iff (!rst_n)
    init_req_o |-> (wait_o && cke_o && cmd_o == seq_cmd));

  p_disabled_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_o && (cfg_mode == 2'd0 || (cfg_mode == 2'd3 && !cfg_mobile))) |=> !wait_o);

  p_precharge_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_o && !init_req_o && cmd_o == 3'b010) |=> (cke_o && cmd_o == 3'b111));

  p_refresh_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_o && !init_req_o && cke_o && cmd_o == 3'b001) |=> (cke_o && cmd_o == 3'b111));

  p_wake_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cke_o) && !init_req_o) |-> (cmd_o == 3'b111 && wait_o));
endmodule

bind sdram_lp_mgr sdram_lp_mgr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_mobile(cfg_mobile),
  .seq_cmd(seq_cmd), .cke_o(cke_o), .cmd_o(cmd_o), .wait_o(wait_o),
  .init_req_o(init_req_o)
);

// File: tb/sdram_lp_mgr_bench.sv
module sdram_lp_mgr_bench;
  localparam int CLK_NS = 10;
  localparam int IS  = 8;
  localparam int IL  = 16;
  localparam int TRP = 3;
  localparam int TRC = 8;
  localparam int TXS = 8;
  localparam int TXP = 1;
  localparam logic [2:0] NOP = 3'b111, PRE = 3'b010, REF = 3'b001, DPD = 3'b110;

  // {mode[13:12], timeout[11:10], mobile[9], enters[8], delay[7:0]}
  localparam logic [13:0] VEC [0:7] = '{
    {2'd1, 2'd0, 1'b0, 1'b1, 8'd1},
    {2'd1, 2'd1, 1'b0, 1'b1, 8'(IS + 1)},
    {2'd2, 2'd2, 1'b0, 1'b1, 8'(IL + 1)},
    {2'd2, 2'd3, 1'b0, 1'b1, 8'(IL + 1)},
    {2'd3, 2'd0, 1'b1, 1'b1, 8'd1},
    {2'd3, 2'd1, 1'b0, 1'b0, 8'd0},
    {2'd0, 2'd0, 1'b1, 1'b0, 8'd0},
    {2'd2, 2'd0, 1'b0, 1'b1, 8'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'd0, cfg_timeout = 2'd0;
  logic cfg_mobile = 1'b0, req = 1'b1, refresh_tick = 1'b0, init_done = 1'b0;
  logic [2:0] seq_cmd = 3'b011;
  logic cke_o, wait_o, init_req_o;
  logic [2:0] cmd_o;
  int n_run = 0, n_fail = 0;

  always #(CLK_NS / 2) clk = ~clk;

  sdram_lp_mgr #(.IDLE_SHORT(IS), .IDLE_LONG(IL), .T_RP(TRP), .T_RC(TRC),
                 .T_XS(TXS), .T_XP(TXP)) u_sdram_lp_mgr (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_timeout(cfg_timeout),
    .cfg_mobile(cfg_mobile), .req(req), .refresh_tick(refresh_tick),
    .init_done(init_done), .seq_cmd(seq_cmd), .cke_o(cke_o), .cmd_o(cmd_o),
    .wait_o(wait_o), .init_req_o(init_req_o));

  task automatic chk(string tag, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d exp %0d", tag, got, exp);
    end
  endtask

  task automatic tick_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_pre(output int k);
    k = 0;
    while (!(cmd_o == PRE && wait_o) && k < IL + 4) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic wake(output int k);
    req = 1'b1;
    k = 0;
    while ((k == 0 || wait_o) && k < 64) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic enter_sleep(logic [1:0] m, logic mob);
    int k;
    cfg_mode = m; cfg_timeout = 2'd0; cfg_mobile = mob;
    req = 1'b1; tick_n(2);
    req = 1'b0;
    wait_pre(k);
    tick_n(TRP + 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int k;
    logic [13:0] v;
    int exp_cmd;
    tick_n(3);
    rst_n = 1'b1;
    tick_n(1);
    chk("R1 cke", int'(cke_o), 1);
    chk("R1 wait", int'(wait_o), 0);
    chk("R1 init_req", int'(init_req_o), 0);
    chk("R1 cmd", int'(cmd_o), 3);

    seq_cmd = 3'b101; tick_n(1);
    chk("R2 passthru", int'(cmd_o), 5);
    seq_cmd = 3'b011;

    for (int i = 0; i < 8; i++) begin
      v = VEC[i];
      cfg_mode = v[13:12]; cfg_timeout = v[11:10]; cfg_mobile = v[9];
      req = 1'b1; tick_n(3);
      req = 1'b0;
      wait_pre(k);
      if (v[8]) begin
        chk("R4 entry delay", k, int'(v[7:0]));
        tick_n(TRP);
        exp_cmd = (v[13:12] == 2'd1) ? int'(REF) : (v[13:12] == 2'd3) ? int'(DPD) : int'(NOP);
        chk("R5 entry cmd", int'(cmd_o), exp_cmd);
        chk("R5 entry cke", int'(cke_o), 0);
        tick_n(1);
        chk("R5 sleep cke", int'(cke_o), 0);
        chk("R6 sleep wait", int'(wait_o), 1);
        if (v[13:12] == 2'd3) begin
          req = 1'b1; tick_n(1);
          chk("R11 init_req", int'(init_req_o), 1);
          chk("R11 cke", int'(cke_o), 1);
          chk("R11 cmd", int'(cmd_o), 3);
          tick_n(4);
          chk("R11 wait held", int'(wait_o), 1);
          init_done = 1'b1; tick_n(1); init_done = 1'b0;
          chk("R11 wait released", int'(wait_o), 0);
          chk("R11 init_req cleared", int'(init_req_o), 0);
        end else begin
          wake(k);
          chk(v[13:12] == 2'd1 ? "R7 exit latency" : "R8 exit latency", k,
              (v[13:12] == 2'd1 ? TXS : TXP) + 1);
        end
      end else begin
        chk("R3 no entry", int'(k == IL + 4 && !wait_o), 1);
      end
      req = 1'b1;
    end

    // R4 idle counter restart
    cfg_mode = 2'd1; cfg_timeout = 2'd1; cfg_mobile = 1'b0;
    req = 1'b1; tick_n(2);
    req = 1'b0; tick_n(IS - 2);
    chk("R4 no early entry", int'(wait_o), 0);
    req = 1'b1; tick_n(1);
    req = 1'b0;
    wait_pre(k);
    chk("R4 restart delay", k, IS + 1);
    tick_n(TRP + 1);
    wake(k);
    chk("R7 exit after restart", k, TXS + 1);

    // R10 tick ignored while awake
    cfg_mode = 2'd0; req = 1'b1; tick_n(2);
    refresh_tick = 1'b1; tick_n(1); refresh_tick = 1'b0;
    chk("R10 awake cmd", int'(cmd_o), 3);
    tick_n(1);
    chk("R10 awake wait", int'(wait_o), 0);

    // R9 power-down refresh
    enter_sleep(2'd2, 1'b0);
    refresh_tick = 1'b1; tick_n(1); refresh_tick = 1'b0;
    chk("R9 wake cke", int'(cke_o), 1);
    chk("R9 wake nop", int'(cmd_o), int'(NOP));
    tick_n(1);
    chk("R9 refresh cmd", int'(cmd_o), int'(REF));
    tick_n(TRC - 1);
    chk("R9 gap cke", int'(cke_o), 1);
    chk("R9 gap nop", int'(cmd_o), int'(NOP));
    tick_n(1);
    chk("R9 back down", int'(cke_o), 0);
    chk("R9 wait", int'(wait_o), 1);
    wake(k);
    chk("R8 exit after refresh", k, TXP + 1);

    // R10 tick ignored in self-refresh, R12 kind latched
    enter_sleep(2'd1, 1'b0);
    refresh_tick = 1'b1; tick_n(1); refresh_tick = 1'b0;
    tick_n(2);
    chk("R10 sr cke", int'(cke_o), 0);
    chk("R10 sr cmd", int'(cmd_o), int'(NOP));
    cfg_mode = 2'd2;
    tick_n(1);
    wake(k);
    chk("R12 latched kind", k, TXS + 1);

    // R6 req during entry
    cfg_mode = 2'd1; cfg_timeout = 2'd0;
    req = 1'b1; tick_n(2);
    req = 1'b0;
    wait_pre(k);
    req = 1'b1;
    k = 0;
    while ((k == 0 || wait_o) && k < 64) begin
      @(negedge clk);
      k++;
      if (k == TRP) chk("R6 entry completes", int'(cke_o), 0);
    end
    chk("R6 release time", k, TRP + 1 + TXS + 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule